// File: doc/BRIEF.md
# Iterative 16-Point FFT Engine

This block computes a 16-point complex fast Fourier transform in fixed point, radix-2 with decimation in time. A single rank of eight butterflies is reused for all four stages. Each stage reads its operands from a bank of sixteen complex working registers. Per-butterfly 4:1 operand multiplexers, steered by the stage counter, pick those operands. The stage results are written back into the same bank, so one stage completes per clock. Each butterfly forms its twiddle product with three real multipliers. It reads a constant table that holds, for each twiddle, the real part together with the precomputed sum and difference of the real and imaginary parts.

To use the block, write the sixteen samples through the load port in bit-reversed address order, pulse `start`, and wait for `done`. Then read the spectrum in natural order through the registered read port. A size-select bit, sampled with `start`, stops the engine after three stages. Each half of the bank then holds an independent 8-point transform.

Top module: `fft16_iter`

## Requirements
- R1: While `rst` is high at a rising edge, `busy` and `done` go low and every working register is cleared, so a read of any address returns zero.
- R2: When `load_en` is high and the engine is idle, the sample on `load_re`/`load_im` is written to address `load_addr`. The read port returns `rd_re`/`rd_im` for the address on `rd_addr` one clock after that address is presented.
- R3: With `half_size` low at start, sample n (n = 0..15) is loaded at the 4-bit bit-reversed address of n. After `done`, address k holds X[k] = sum of x[n]·exp(-j·2πkn/16), within 16 LSB on each component. Twiddles are Q14 values, and products are rounded half-up.
- R4: A `start` accepted while idle raises `busy` at the next edge. For a 16-point transform, `done` rises at the fourth edge after the start edge, and `busy` falls at that same edge. `busy` and `done` are never high together.
- R5: With `half_size` high at start, the engine runs three stages and `done` rises at the third edge after the start edge. Addresses 0..7 and 8..15 each hold an 8-point transform of the eight samples loaded into that half. Within a half, local sample m is loaded at offset bit-reversed(m, 3 bits).
- R6: While `busy` is high, `start` and `load_en` are ignored. The stage counter advances by one per clock, and the result and its timing are unchanged.
- R7: After `done`, the working registers and `done` hold their values until the next accepted `start` or `load_en`. Either of these clears `done`.
- R8: Every butterfly result fits the DATA_W-bit signed range. This holds when each input component lies within ±2^(DATA_W-1)/(16·√2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one sample into the working bank |
| load_addr | input | 4 | Working-bank address for the load |
| load_re | input | DATA_W | Real part of the loaded sample |
| load_im | input | DATA_W | Imaginary part of the loaded sample |
| start | input | 1 | Begin a transform (accepted only when idle) |
| half_size | input | 1 | Size select sampled with start: 1 = two 8-point transforms |
| rd_addr | input | 4 | Read address |
| rd_re | output | DATA_W | Registered real part at rd_addr |
| rd_im | output | DATA_W | Registered imaginary part at rd_addr |
| busy | output | 1 | Stages in progress |
| done | output | 1 | Results valid in the bank |

## Verification
The overflow assertions assume that the caller never loads components large enough to push a stage sum past the data width. This is the input bound stated in R8. The stimulus keeps every component within ±1000 on a 16-bit path, so the worst-case spectrum magnitude stays below 23 000. The hold assertion assumes that reads use a stable address, and the bench presents each read address for a full clock before sampling. Impulses swept over every position, a DC vector, and random vectors in both size modes exercise each twiddle and each routing of the operand multiplexers.

// File: rtl/fft_pkg.sv
package fft_pkg;
  localparam int FFT_N   = 16;
  localparam int LOG_N   = 4;
  localparam int N_BFLY  = FFT_N / 2;
  localparam int ADDR_W  = LOG_N;
  localparam int STAGE_W = 2;
  localparam int TWI_W   = LOG_N - 1;
  localparam int TW_W    = 16;
  localparam int TW_FRAC = 14;

  // Lower operand index of butterfly b in stage s (span 2^s).
  function automatic int bf_top(input int b, input int s);
    int h;
    h = 1 << s;
    return ((b >> s) * 2 * h) + (b & (h - 1));
  endfunction

  function automatic int bf_bot(input int b, input int s);
    return bf_top(b, s) + (1 << s);
  endfunction

  // Twiddle exponent e of W16^e used by butterfly b in stage s.
  function automatic int bf_twe(input int b, input int s);
    return (b & ((1 << s) - 1)) << (LOG_N - 1 - s);
  endfunction
endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom
  import fft_pkg::*;
(
  input  logic [TWI_W-1:0]       idx,
  output logic signed [TW_W-1:0] tw_c,
  output logic signed [TW_W-1:0] tw_cmd,
  output logic signed [TW_W-1:0] tw_cpd
);
  // W = c + j*d with d = -sin. Entries: c, c-d, c+d in Q14.
  always_comb begin
    case (idx)
      3'd0: begin tw_c =  16'sd16384; tw_cmd =  16'sd16384; tw_cpd =  16'sd16384; end
      3'd1: begin tw_c =  16'sd15137; tw_cmd =  16'sd21407; tw_cpd =  16'sd8867;  end
      3'd2: begin tw_c =  16'sd11585; tw_cmd =  16'sd23170; tw_cpd =  16'sd0;     end
      3'd3: begin tw_c =  16'sd6270;  tw_cmd =  16'sd21407; tw_cpd = -16'sd8867;  end
      3'd4: begin tw_c =  16'sd0;     tw_cmd =  16'sd16384; tw_cpd = -16'sd16384; end
      3'd5: begin tw_c = -16'sd6270;  tw_cmd =  16'sd8867;  tw_cpd = -16'sd21407; end
      3'd6: begin tw_c = -16'sd11585; tw_cmd =  16'sd0;     tw_cpd = -16'sd23170; end
      default: begin tw_c = -16'sd15137; tw_cmd = -16'sd8867; tw_cpd = -16'sd21407; end
    endcase
  end
endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly
  import fft_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     chk_en,
  input  logic signed [DATA_W-1:0] x0_re,
  input  logic signed [DATA_W-1:0] x0_im,
  input  logic signed [DATA_W-1:0] x1_re,
  input  logic signed [DATA_W-1:0] x1_im,
  input  logic signed [TW_W-1:0]   tw_c,
  input  logic signed [TW_W-1:0]   tw_cmd,
  input  logic signed [TW_W-1:0]   tw_cpd,
  output logic signed [DATA_W-1:0] y0_re,
  output logic signed [DATA_W-1:0] y0_im,
  output logic signed [DATA_W-1:0] y1_re,
  output logic signed [DATA_W-1:0] y1_im
);
  localparam int PW  = DATA_W + TW_W + 2;
  localparam int DEX = PW - DATA_W;
  localparam int TEX = PW - TW_W;
  localparam logic signed [PW-1:0] RND = PW'(1) << (TW_FRAC - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [PW-1:0] a0, b0, a1, b1, c, cmd, cpd;
  logic signed [PW-1:0] shared_t, pr_full, pi_full, p_re, p_im;
  logic signed [PW-1:0] s_re, s_im, d_re, d_im;

  always_comb begin
    a0  = $signed({{DEX{x0_re[DATA_W-1]}}, x0_re});
    b0  = $signed({{DEX{x0_im[DATA_W-1]}}, x0_im});
    a1  = $signed({{DEX{x1_re[DATA_W-1]}}, x1_re});
    b1  = $signed({{DEX{x1_im[DATA_W-1]}}, x1_im});
    c   = $signed({{TEX{tw_c[TW_W-1]}},   tw_c});
    cmd = $signed({{TEX{tw_cmd[TW_W-1]}}, tw_cmd});
    cpd = $signed({{TEX{tw_cpd[TW_W-1]}}, tw_cpd});
    // Three multipliers: shared c*(a-b), then b*(c-d) and a*(c+d).
    shared_t = c * (a1 - b1);
    pr_full  = shared_t + b1 * cmd;
    pi_full  = a1 * cpd - shared_t;
    p_re     = (pr_full + RND) >>> TW_FRAC;
    p_im     = (pi_full + RND) >>> TW_FRAC;
    s_re     = a0 + p_re;
    s_im     = b0 + p_im;
    d_re     = a0 - p_re;
    d_im     = b0 - p_im;
    y0_re    = s_re[DATA_W-1:0];
    y0_im    = s_im[DATA_W-1:0];
    y1_re    = d_re[DATA_W-1:0];
    y1_im    = d_im[DATA_W-1:0];
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    chk_en |-> (s_re <= MAXV && s_re >= MINV && s_im <= MAXV && s_im >= MINV &&
                d_re <= MAXV && d_re >= MINV && d_im <= MAXV && d_im >= MINV));
endmodule

// File: rtl/fft_ctrl.sv
module fft_ctrl
  import fft_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               half_size,
  input  logic               load_en,
  output logic               busy,
  output logic               done,
  output logic [STAGE_W-1:0] stage
);
  logic               half_q;
  logic [STAGE_W-1:0] last_stage;

  assign last_stage = half_q ? STAGE_W'(LOG_N - 2) : STAGE_W'(LOG_N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      stage  <= '0;
      half_q <= 1'b0;
    end else if (busy) begin
      if (stage == last_stage) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        stage <= '0;
      end else begin
        stage <= stage + 1'b1;
      end
    end else if (start) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      stage  <= '0;
      half_q <= half_size;
    end else if (load_en) begin
      done <= 1'b0;
    end
  end

  assert_start_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && stage == '0 && !done));
  assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
  assert_stage_step_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && stage != last_stage) |=> (busy && stage == $past(stage) + 1'b1));
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !start && !load_en) |=> done);
endmodule

// File: rtl/fft16_iter.sv
module fft16_iter
  import fft_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_en,
  input  logic [ADDR_W-1:0]        load_addr,
  input  logic signed [DATA_W-1:0] load_re,
  input  logic signed [DATA_W-1:0] load_im,
  input  logic                     start,
  input  logic                     half_size,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic signed [DATA_W-1:0] rd_re,
  output logic signed [DATA_W-1:0] rd_im,
  output logic                     busy,
  output logic                     done
);
  logic signed [DATA_W-1:0] bank_re [FFT_N];
  logic signed [DATA_W-1:0] bank_im [FFT_N];
  logic [STAGE_W-1:0]       stage;

  logic [ADDR_W-1:0]        top_idx [N_BFLY];
  logic [ADDR_W-1:0]        bot_idx [N_BFLY];
  logic signed [DATA_W-1:0] y0_re [N_BFLY];
  logic signed [DATA_W-1:0] y0_im [N_BFLY];
  logic signed [DATA_W-1:0] y1_re [N_BFLY];
  logic signed [DATA_W-1:0] y1_im [N_BFLY];

  fft_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .half_size (half_size),
    .load_en   (load_en),
    .busy      (busy),
    .done      (done),
    .stage     (stage)
  );

  for (genvar g = 0; g < N_BFLY; g++) begin : g_bfly
    logic [TWI_W-1:0]        tw_idx;
    logic signed [TW_W-1:0]  tw_c, tw_cmd, tw_cpd;

    // Stage-selected operand routing (4:1 per operand).
    always_comb begin
      top_idx[g] = ADDR_W'(bf_top(g, int'(stage)));
      bot_idx[g] = ADDR_W'(bf_bot(g, int'(stage)));
      tw_idx     = TWI_W'(bf_twe(g, int'(stage)));
    end

    fft_twiddle_rom u_rom (
      .idx    (tw_idx),
      .tw_c   (tw_c),
      .tw_cmd (tw_cmd),
      .tw_cpd (tw_cpd)
    );

    fft_butterfly #(.DATA_W(DATA_W)) u_bf (
      .clk    (clk),
      .rst    (rst),
      .chk_en (busy),
      .x0_re  (bank_re[top_idx[g]]),
      .x0_im  (bank_im[top_idx[g]]),
      .x1_re  (bank_re[bot_idx[g]]),
      .x1_im  (bank_im[bot_idx[g]]),
      .tw_c   (tw_c),
      .tw_cmd (tw_cmd),
      .tw_cpd (tw_cpd),
      .y0_re  (y0_re[g]),
      .y0_im  (y0_im[g]),
      .y1_re  (y1_re[g]),
      .y1_im  (y1_im[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FFT_N; i++) begin
        bank_re[i] <= '0;
        bank_im[i] <= '0;
      end
    end else if (busy) begin
      for (int b = 0; b < N_BFLY; b++) begin
        bank_re[top_idx[b]] <= y0_re[b];
        bank_im[top_idx[b]] <= y0_im[b];
        bank_re[bot_idx[b]] <= y1_re[b];
        bank_im[bot_idx[b]] <= y1_im[b];
      end
    end else if (load_en) begin
      bank_re[load_addr] <= load_re;
      bank_im[load_addr] <= load_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_re <= '0;
      rd_im <= '0;
    end else begin
      rd_re <= bank_re[rd_addr];
      rd_im <= bank_im[rd_addr];
    end
  end

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done) && !$past(load_en) && !$past(rst) && $stable(rd_addr))
    |=> ($stable(rd_re) && $stable(rd_im)));
  assert_reset_read_R1: assert property (@(posedge clk)
    $past(rst) && rst |-> (rd_re == '0 && rd_im == '0 && !busy && !done));
endmodule

// File: tb/test_fft16_iter.sv
module test_fft16_iter;
  localparam int DW  = 16;
  localparam int TOL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic [3:0] load_addr = '0;
  logic signed [DW-1:0] load_re = '0, load_im = '0;
  logic start = 1'b0, half_size = 1'b0;
  logic [3:0] rd_addr = '0;
  logic signed [DW-1:0] rd_re, rd_im;
  logic busy, done;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int xr [16];
  int xi [16];
  real er [16];
  real ei [16];

  always #5 clk = ~clk;

  fft16_iter #(.DATA_W(DW)) i_fft16_iter (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_re(load_re), .load_im(load_im), .start(start), .half_size(half_size),
    .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] load_pos(input int n, input bit half);
    logic [3:0] v, r;
    v = 4'(n);
    if (half) r = {v[3], v[0], v[1], v[2]};
    else      r = {v[0], v[1], v[2], v[3]};
    return r;
  endfunction

  task automatic load_all(input bit half);
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = load_pos(n, half);
      load_re = DW'(xr[n]); load_im = DW'(xi[n]);
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic compute_expected(input bit half);
    real pi2, ang;
    int len, blk, kk;
    pi2 = 6.283185307179586;
    len = half ? 8 : 16;
    for (int k = 0; k < 16; k++) begin
      blk = half ? (k / 8) * 8 : 0;
      kk  = half ? k % 8 : k;
      er[k] = 0.0; ei[k] = 0.0;
      for (int m = 0; m < len; m++) begin
        ang = pi2 * kk * m / len;
        er[k] += xr[blk + m] * $cos(ang) + xi[blk + m] * $sin(ang);
        ei[k] += xi[blk + m] * $cos(ang) - xr[blk + m] * $sin(ang);
      end
    end
  endtask

  // Start a transform; optionally disturb it while busy (R6).
  task automatic run(input bit half, input bit disturb, input string req);
    int lat;
    bit ok;
    lat = half ? 3 : 4;
    @(negedge clk);
    start = 1'b1; half_size = half;
    @(negedge clk);
    start = 1'b0;
    ok = busy && !done;
    for (int i = 1; i <= lat; i++) begin
      if (disturb && i == 2) begin
        start = 1'b1; load_en = 1'b1; load_addr = 4'd0;
        load_re = 16'sd7777; load_im = -16'sd7777;
      end
      @(negedge clk);
      start = 1'b0; load_en = 1'b0;
      if (done != (i == lat)) ok = 0;
      if (busy != (i != lat)) ok = 0;
    end
    chk(ok, req, "done/busy timing", int'(done), 1);
  endtask

  task automatic read_at(input int a, output int re, output int im);
    @(negedge clk);
    rd_addr = 4'(a);
    @(negedge clk);
    re = int'(rd_re); im = int'(rd_im);
  endtask

  task automatic check_spectrum(input bit half, input string req);
    int ar, ai, exr, exi;
    compute_expected(half);
    for (int k = 0; k < 16; k++) begin
      read_at(k, ar, ai);
      exr = $rtoi(er[k] + (er[k] >= 0.0 ? 0.5 : -0.5));
      exi = $rtoi(ei[k] + (ei[k] >= 0.0 ? 0.5 : -0.5));
      chk((ar - exr <= TOL) && (exr - ar <= TOL), req, $sformatf("bin %0d re", k), ar, exr);
      chk((ai - exi <= TOL) && (exi - ai <= TOL), req, $sformatf("bin %0d im", k), ai, exi);
    end
  endtask

  task automatic fill_random();
    for (int n = 0; n < 16; n++) begin
      xr[n] = int'($urandom_range(0, 2000)) - 1000;
      xi[n] = int'($urandom_range(0, 2000)) - 1000;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ar, ai;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!busy && !done, "R1", "busy/done after reset", int'(busy) + int'(done), 0);
    read_at(5, ar, ai);
    chk(ar == 0 && ai == 0, "R1", "read after reset", ar, 0);

    // R2: load then read back raw samples before start
    for (int n = 0; n < 16; n++) begin xr[n] = 10 * n - 70; xi[n] = 3 - n; end
    load_all(1'b0);
    for (int n = 0; n < 16; n++) begin
      read_at(int'(load_pos(n, 1'b0)), ar, ai);
      chk(ar == xr[n] && ai == xi[n], "R2", $sformatf("raw sample %0d", n), ar, xr[n]);
    end

    // R3/R4: impulse sweep over every position
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < 16; n++) begin xr[n] = 0; xi[n] = 0; end
      xr[p] = 1000; xi[p] = (p % 2 == 0) ? -500 : 700;
      load_all(1'b0);
      run(1'b0, 1'b0, "R4");
      check_spectrum(1'b0, "R3");
    end
    // R3: DC vector and random vectors
    for (int n = 0; n < 16; n++) begin xr[n] = 1000; xi[n] = -1000; end
    load_all(1'b0); run(1'b0, 1'b0, "R4"); check_spectrum(1'b0, "R3");
    for (int t = 0; t < 8; t++) begin
      fill_random(); load_all(1'b0); run(1'b0, 1'b0, "R4"); check_spectrum(1'b0, "R3");
    end

    // R5: two 8-point transforms
    for (int p = 0; p < 8; p++) begin
      for (int n = 0; n < 16; n++) begin xr[n] = 0; xi[n] = 0; end
      xr[p] = 900; xr[15 - p] = -600; xi[8 + p] = 400;
      load_all(1'b1); run(1'b1, 1'b0, "R5"); check_spectrum(1'b1, "R5");
    end
    for (int t = 0; t < 4; t++) begin
      fill_random(); load_all(1'b1); run(1'b1, 1'b0, "R5"); check_spectrum(1'b1, "R5");
    end

    // R6: start and load while busy are ignored
    fill_random(); load_all(1'b0);
    run(1'b0, 1'b1, "R6");
    check_spectrum(1'b0, "R6");

    // R7: results and done hold, then load clears done
    repeat (10) @(negedge clk);
    chk(done, "R7", "done held", int'(done), 1);
    read_at(3, ar, ai);
    chk((ar - $rtoi(er[3]) <= TOL + 1) && ($rtoi(er[3]) - ar <= TOL + 1), "R7",
        "bin 3 held", ar, $rtoi(er[3]));
    @(negedge clk);
    load_en = 1'b1; load_addr = 4'd9; load_re = 16'sd1; load_im = 16'sd2;
    @(negedge clk);
    load_en = 1'b0;
    chk(!done, "R7", "done cleared by load", int'(done), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule